// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit moves the bits of a 32-bit operand by a variable count in one of seven ways. The ways are logical shift left, logical shift right, arithmetic shift right, rotate left, rotate right, rotate left through carry and rotate right through carry. An eighth code passes the operand through unchanged. The caller supplies the current carry flag with every request. The unit returns the moved value together with a new carry flag, which always holds the last bit that crossed the operand's edge. For the two through-carry rotates, the carry and the operand together form a 33-bit ring.

The count comes from one of two sources. One is a narrow immediate field. The other is the low byte of a register, which can reach 255. A multi-bit count gives the same result as repeating a one-bit step that many times, but the unit computes it in a single pass. A request is captured on a clock edge while the valid input is high. The result, the carry, a zero flag and a negative flag appear on registered outputs one cycle later and stay there until the next request.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is applied, and after it is released, every output reads 0 until the first request is captured.
- R2: A request presented with in_valid high appears on the outputs after the next rising clock edge, and out_valid is high in that cycle. In a cycle after in_valid was low, out_valid is low and out_result and out_carry keep their previous values.
- R3: in_cnt_sel = 0 takes the count from in_imm_cnt, zero-extended (0 to 31). in_cnt_sel = 1 takes it from in_reg_cnt (0 to 255). The unused source has no effect.
- R4: A count of 0 returns the operand unchanged and returns in_carry as the carry, for every operation code.
- R5: Logical shifts (code 0 = left, code 1 = right) fill vacated bits with zeros, and the carry is the last bit shifted out. A count of exactly 32 clears the result and returns the end bit (bit 0 for left, bit 31 for right) as carry. Counts above 32 give a result of 0 and a carry of 0.
- R6: Arithmetic right shift (code 2) fills vacated bits with copies of bit 31, and the carry is the last bit shifted out. Counts of 32 or more give 32 copies of bit 31, with that bit as the carry.
- R7: Rotates without carry (code 3 = left, code 4 = right) feed the exiting bit back in at the other end, and the count wraps modulo 32. For a nonzero count the carry equals the last moved bit: result bit 0 for left, result bit 31 for right.
- R8: Rotates through carry (code 5 = left, code 6 = right) turn the 33-bit ring {carry, operand} with the count taken modulo 33. The old carry enters the vacated end of the operand, and the bit leaving the operand becomes the new carry.
- R9: out_zero is high exactly when the captured result is 0, and out_neg equals bit 31 of the captured result.
- R10: Code 7 returns the operand and in_carry unchanged, whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, captures the inputs |
| in_op | input | 3 | Operation code |
| in_operand | input | 32 | Value to move |
| in_carry | input | 1 | Current carry flag |
| in_cnt_sel | input | 1 | Count source: 0 immediate, 1 register |
| in_imm_cnt | input | 5 | Immediate count |
| in_reg_cnt | input | 8 | Register count |
| out_valid | output | 1 | Result of a captured request is present |
| out_result | output | 32 | Moved value |
| out_carry | output | 1 | New carry flag |
| out_zero | output | 1 | Result equals zero |
| out_neg | output | 1 | Bit 31 of the result |

## Verification
The bench builds the unit with its defaults: a 32-bit operand, a 5-bit immediate count and an 8-bit register count. With an 8-bit register count, the bench can apply counts of exactly 32, just above 32, and several whole turns of both the 32-bit and the 33-bit rings. These are the cases where shifts flush, the arithmetic shift saturates to its sign, and the modulo reductions wrap. The immediate path only reaches counts below 32, so the bench drives deliberately different values on the two count sources to expose a wrong selection.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROTL = 3'd3,
    OP_ROTR = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_PASS = 3'd7
  } sru_op_e;

endpackage

// File: rtl/sru_count_sel.sv
// Picks the count source and reduces it for the ring widths.
module sru_count_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8,
  localparam int CW    = REG_W,
  localparam int AW    = $clog2(DATA_W),
  localparam int RW    = $clog2(DATA_W + 1)
) (
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [REG_W-1:0] reg_cnt,
  input  logic             use_reg,
  output logic             cnt_zero,
  output logic             cnt_ge_w,
  output logic             cnt_eq_w,
  output logic [AW-1:0]    amt_w,
  output logic [RW-1:0]    amt_ring
);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt      = use_reg ? reg_cnt : CW'(imm_cnt);
    cnt_zero = (cnt == '0);
    cnt_ge_w = (int'(cnt) >= DATA_W);
    cnt_eq_w = (int'(cnt) == DATA_W);
    amt_w    = AW'(int'(cnt) % DATA_W);
    amt_ring = RW'(int'(cnt) % (DATA_W + 1));
  end

endmodule

// File: rtl/sru_rotr.sv
// Logarithmic rotate-right network over W bits.
module sru_rotr #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [0:AW];

  assign stg[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
  end

  assign dout = stg[AW];

endmodule

// File: rtl/sru_core.sv
// Forms result and carry for every operation from two rotators and masks.
module sru_core
  import sru_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DATA_W),
  localparam int RW    = $clog2(DATA_W + 1)
) (
  input  sru_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              cnt_zero,
  input  logic              cnt_ge_w,
  input  logic              cnt_eq_w,
  input  logic [AW-1:0]     amt_w,
  input  logic [RW-1:0]     amt_ring,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic              is_left;
  logic [AW-1:0]     left_amt;
  logic [AW-1:0]     rot_amt;
  logic [DATA_W-1:0] rot_w;
  logic [RW-1:0]     ring_amt;
  logic [DATA_W:0]   ring_out;
  logic [DATA_W-1:0] mask_r;
  logic [DATA_W-1:0] mask_l;
  logic [AW-1:0]     idx_r;
  logic [AW-1:0]     idx_l;
  logic              out_r_bit;
  logic              out_l_bit;
  logic              sign;

  always_comb begin
    is_left  = (op == OP_SHL) || (op == OP_ROTL);
    left_amt = AW'((DATA_W - int'(amt_w)) % DATA_W);
    rot_amt  = is_left ? left_amt : amt_w;
    ring_amt = (op == OP_RCR) ? amt_ring
                              : RW'((DATA_W + 1 - int'(amt_ring)) % (DATA_W + 1));
    mask_r    = {DATA_W{1'b1}} >> amt_w;
    mask_l    = {DATA_W{1'b1}} << amt_w;
    idx_r     = amt_w - 1'b1;
    idx_l     = left_amt;
    sign      = a[DATA_W-1];
    out_r_bit = cnt_eq_w ? a[DATA_W-1] : a[idx_r];
    out_l_bit = cnt_eq_w ? a[0]        : a[idx_l];
  end

  sru_rotr #(.W(DATA_W)) u_rot_w (
    .din  (a),
    .amt  (rot_amt),
    .dout (rot_w)
  );

  sru_rotr #(.W(DATA_W + 1)) u_rot_ring (
    .din  ({cin, a}),
    .amt  (ring_amt),
    .dout (ring_out)
  );

  always_comb begin
    res  = a;
    cout = cin;
    unique case (op)
      OP_SHL: begin
        res  = cnt_ge_w ? '0 : (rot_w & mask_l);
        cout = (cnt_ge_w && !cnt_eq_w) ? 1'b0 : out_l_bit;
      end
      OP_SHR: begin
        res  = cnt_ge_w ? '0 : (rot_w & mask_r);
        cout = (cnt_ge_w && !cnt_eq_w) ? 1'b0 : out_r_bit;
      end
      OP_SAR: begin
        res  = cnt_ge_w ? {DATA_W{sign}}
                        : ((rot_w & mask_r) | (sign ? ~mask_r : '0));
        cout = (cnt_ge_w && !cnt_eq_w) ? sign : out_r_bit;
      end
      OP_ROTL: begin
        res  = rot_w;
        cout = rot_w[0];
      end
      OP_ROTR: begin
        res  = rot_w;
        cout = rot_w[DATA_W-1];
      end
      OP_RCL, OP_RCR: begin
        res  = ring_out[DATA_W-1:0];
        cout = ring_out[DATA_W];
      end
      default: begin
        res  = a;
        cout = cin;
      end
    endcase
    if (cnt_zero) begin
      res  = a;
      cout = cin;
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8,
  localparam int AW    = $clog2(DATA_W),
  localparam int RW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_carry,
  input  logic              in_cnt_sel,
  input  logic [IMM_W-1:0]  in_imm_cnt,
  input  logic [REG_W-1:0]  in_reg_cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_zero,
  output logic              out_neg
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic              cnt_zero;
  logic              cnt_ge_w;
  logic              cnt_eq_w;
  logic [AW-1:0]     amt_w;
  logic [RW-1:0]     amt_ring;
  logic [DATA_W-1:0] core_res;
  logic              core_cout;

  sru_count_sel #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .REG_W  (REG_W)
  ) u_cnt (
    .imm_cnt  (in_imm_cnt),
    .reg_cnt  (in_reg_cnt),
    .use_reg  (in_cnt_sel),
    .cnt_zero (cnt_zero),
    .cnt_ge_w (cnt_ge_w),
    .cnt_eq_w (cnt_eq_w),
    .amt_w    (amt_w),
    .amt_ring (amt_ring)
  );

  sru_core #(.DATA_W(DATA_W)) u_core (
    .op       (sru_op_e'(in_op)),
    .a        (in_operand),
    .cin      (in_carry),
    .cnt_zero (cnt_zero),
    .cnt_ge_w (cnt_ge_w),
    .cnt_eq_w (cnt_eq_w),
    .amt_w    (amt_w),
    .amt_ring (amt_ring),
    .res      (core_res),
    .cout     (core_cout)
  );

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              cy_q,  cy_d;
  logic              zf_q,  zf_d;
  logic              nf_q,  nf_d;

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    cy_d  = cy_q;
    zf_d  = zf_q;
    nf_d  = nf_q;
    if (in_valid) begin
      res_d = core_res;
      cy_d  = core_cout;
      zf_d  = (core_res == '0);
      nf_d  = core_res[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      cy_q  <= 1'b0;
      zf_q  <= 1'b0;
      nf_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      cy_q  <= cy_d;
      zf_q  <= zf_d;
      nf_q  <= nf_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_carry  = cy_q;
  assign out_zero   = zf_q;
  assign out_neg    = nf_q;

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_operand,
  input logic              in_carry,
  input logic              in_cnt_sel,
  input logic [IMM_W-1:0]  in_imm_cnt,
  input logic [REG_W-1:0]  in_reg_cnt,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry,
  input logic              out_zero,
  input logic              out_neg
);

  logic [REG_W-1:0] eff_cnt;
  assign eff_cnt = in_cnt_sel ? in_reg_cnt : REG_W'(in_imm_cnt);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry))); // R2

  AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_cnt == '0) |=>
      (out_result == $past(in_operand) && out_carry == $past(in_carry))); // R4

  AST_SHIFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 3'd0 || in_op == 3'd1) && int'(eff_cnt) > DATA_W) |=>
      (out_result == '0 && !out_carry)); // R5

  AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd3 && eff_cnt != '0) |=> (out_carry == out_result[0])); // R7

  AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_zero == (out_result == '0)) && (out_neg == out_result[DATA_W-1]))); // R9

  AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd7) |=>
      (out_result == $past(in_operand) && out_carry == $past(in_carry))); // R10

endmodule

bind shift_rotate_unit sru_checker #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .REG_W  (REG_W)
) u_sru_checker (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_operand (in_operand),
  .in_carry   (in_carry),
  .in_cnt_sel (in_cnt_sel),
  .in_imm_cnt (in_imm_cnt),
  .in_reg_cnt (in_reg_cnt),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_carry  (out_carry),
  .out_zero   (out_zero),
  .out_neg    (out_neg)
);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [31:0] in_operand;
  logic        in_carry;
  logic        in_cnt_sel;
  logic [4:0]  in_imm_cnt;
  logic [7:0]  in_reg_cnt;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_zero;
  logic        out_neg;

  int n_checks = 0;
  int n_fails  = 0;

  logic        exp_v;
  logic [31:0] exp_r;
  logic        exp_c;

  shift_rotate_unit u_shift_rotate_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_operand (in_operand),
    .in_carry   (in_carry),
    .in_cnt_sel (in_cnt_sel),
    .in_imm_cnt (in_imm_cnt),
    .in_reg_cnt (in_reg_cnt),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry),
    .out_zero   (out_zero),
    .out_neg    (out_neg)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Reference: repeat one-bit steps.
  function automatic logic [32:0] ref_move(input logic [2:0] op, input logic [31:0] a,
                                           input logic c, input int n);
    logic t;
    if (op == 3'd7) return {c, a};
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0: begin c = a[31]; a = a << 1; end
        3'd1: begin c = a[0];  a = a >> 1; end
        3'd2: begin c = a[0];  a = {a[31], a[31:1]}; end
        3'd3: begin c = a[31]; a = {a[30:0], a[31]}; end
        3'd4: begin c = a[0];  a = {a[0], a[31:1]}; end
        3'd5: begin t = a[31]; a = {a[30:0], c}; c = t; end
        default: begin t = a[0]; a = {c, a[31:1]}; c = t; end
      endcase
    end
    return {c, a};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                      input logic c, input logic [4:0] imm, input logic [7:0] rc,
                      input logic sel, input string tag);
    logic [32:0] m;
    in_valid   = v;
    in_op      = op;
    in_operand = a;
    in_carry   = c;
    in_imm_cnt = imm;
    in_reg_cnt = rc;
    in_cnt_sel = sel;
    @(posedge clk);
    #1;
    exp_v = v;
    if (v) begin
      m     = ref_move(op, a, c, sel ? int'(rc) : int'(imm));
      exp_c = m[32];
      exp_r = m[31:0];
    end
    @(negedge clk);
    check("R2", "valid", 32'(out_valid), 32'(exp_v));
    check(v ? tag : "R2", "result", out_result, exp_r);
    check(v ? tag : "R2", "carry", 32'(out_carry), 32'(exp_c));
    if (v) begin
      check("R9", "zero", 32'(out_zero), 32'(exp_r == 32'd0));
      check("R9", "neg", 32'(out_neg), 32'(exp_r[31]));
    end
  endtask

  task automatic reg_op(input logic [2:0] op, input logic [31:0] a, input logic c,
                        input logic [7:0] n, input string tag);
    step(1'b1, op, a, c, 5'd17, n, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    in_valid = 0; in_op = 0; in_operand = 0; in_carry = 0;
    in_cnt_sel = 0; in_imm_cnt = 0; in_reg_cnt = 0;
    exp_v = 0; exp_r = 0; exp_c = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", 32'(out_valid), 32'd0);
    check("R1", "result in reset", out_result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "valid", 32'(out_valid), 32'd0);
    check("R1", "result", out_result, 32'd0);
    check("R1", "carry", 32'(out_carry), 32'd0);
    check("R1", "zero", 32'(out_zero), 32'd0);
    check("R1", "neg", 32'(out_neg), 32'd0);

    // R4: zero count for every code, both sources
    for (int op = 0; op < 8; op++) begin
      step(1'b1, 3'(op), 32'hA5C3_0F81, 1'b1, 5'd0, 8'd9, 1'b0, "R4");
      step(1'b1, 3'(op), 32'h1234_5678, 1'b0, 5'd7, 8'd0, 1'b1, "R4");
    end
    // R3: the other source must not matter
    step(1'b1, 3'd1, 32'hF000_00F0, 1'b0, 5'd9, 8'd4, 1'b1, "R3");
    step(1'b1, 3'd1, 32'hF000_00F0, 1'b0, 5'd9, 8'd4, 1'b0, "R3");
    step(1'b1, 3'd0, 32'h8000_0001, 1'b0, 5'd31, 8'd200, 1'b0, "R3");
    // R5
    reg_op(3'd0, 32'hC000_0003, 1'b0, 8'd1, "R5");
    reg_op(3'd0, 32'h0000_0003, 1'b1, 8'd31, "R5");
    reg_op(3'd0, 32'h0000_0001, 1'b0, 8'd32, "R5");
    reg_op(3'd0, 32'hFFFF_FFFF, 1'b1, 8'd33, "R5");
    reg_op(3'd0, 32'hFFFF_FFFF, 1'b1, 8'd200, "R5");
    reg_op(3'd1, 32'h8000_0001, 1'b0, 8'd1, "R5");
    reg_op(3'd1, 32'hC000_0000, 1'b0, 8'd31, "R5");
    reg_op(3'd1, 32'h8000_0000, 1'b0, 8'd32, "R5");
    reg_op(3'd1, 32'hFFFF_FFFF, 1'b1, 8'd40, "R5");
    // R6
    reg_op(3'd2, 32'h8000_0010, 1'b0, 8'd5, "R6");
    reg_op(3'd2, 32'h7000_0010, 1'b1, 8'd5, "R6");
    reg_op(3'd2, 32'h8000_0000, 1'b0, 8'd32, "R6");
    reg_op(3'd2, 32'h8123_4567, 1'b0, 8'd40, "R6");
    reg_op(3'd2, 32'h7FFF_FFFF, 1'b1, 8'd255, "R6");
    // R7
    reg_op(3'd3, 32'h8000_0000, 1'b0, 8'd1, "R7");
    reg_op(3'd3, 32'h1234_5679, 1'b0, 8'd32, "R7");
    reg_op(3'd3, 32'hDEAD_BEEF, 1'b1, 8'd37, "R7");
    reg_op(3'd4, 32'h0000_0005, 1'b0, 8'd3, "R7");
    reg_op(3'd4, 32'hCAFE_0000, 1'b1, 8'd64, "R7");
    // R8
    reg_op(3'd5, 32'h8000_0000, 1'b1, 8'd1, "R8");
    reg_op(3'd5, 32'h1357_9BDF, 1'b1, 8'd33, "R8");
    reg_op(3'd5, 32'h1357_9BDF, 1'b0, 8'd34, "R8");
    reg_op(3'd5, 32'hF0F0_1234, 1'b1, 8'd100, "R8");
    reg_op(3'd6, 32'h0000_0001, 1'b0, 8'd1, "R8");
    reg_op(3'd6, 32'h0000_0001, 1'b1, 8'd32, "R8");
    reg_op(3'd6, 32'hABCD_EF01, 1'b1, 8'd33, "R8");
    // R9 and R10
    reg_op(3'd1, 32'h0000_0001, 1'b0, 8'd1, "R9");
    reg_op(3'd2, 32'h8000_0000, 1'b0, 8'd3, "R9");
    reg_op(3'd7, 32'h0BAD_F00D, 1'b1, 8'd5, "R10");
    // R2: idle cycles with moving inputs
    step(1'b0, 3'd0, 32'hFFFF_FFFF, 1'b1, 5'd3, 8'd3, 1'b0, "R2");
    step(1'b0, 3'd5, 32'h0, 1'b0, 5'd1, 8'd1, 1'b1, "R2");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [7:0] rc;
      logic [4:0] im;
      logic       sel;
      string      tag;
      op  = 3'($urandom_range(0, 7));
      rc  = 8'($urandom_range(0, 255));
      im  = 5'($urandom_range(0, 31));
      sel = 1'($urandom_range(0, 1));
      case (op)
        3'd0, 3'd1: tag = "R5";
        3'd2:       tag = "R6";
        3'd3, 3'd4: tag = "R7";
        3'd5, 3'd6: tag = "R8";
        default:    tag = "R10";
      endcase
      if ((sel ? int'(rc) : int'(im)) == 0) tag = "R4";
      step(($urandom_range(0, 3) != 0), op, $urandom, 1'($urandom_range(0, 1)),
           im, rc, sel, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule